// File: doc/BRIEF.md
# Atomic Load-Linked / Store-Conditional Reservation Unit

This unit sits between a core's load/store issue path and a word-addressed memory port. It executes two word-sized atomic operations. A load-linked reads one word, returns it for the destination register, and records a reservation made of the byte address and the value that came back. A store-conditional writes only when two things are true. Its address must equal the reserved address, and memory must still hold the reserved value at that moment. The unit reports the outcome on a result flag. Any store-conditional that is properly aligned discards the reservation, whether it succeeds or fails.

The effective address is formed from a base operand plus a sign-extended immediate. The memory side uses a simple request/grant handshake, with read data returned on a separate valid strobe. The unit raises a lock output from the store-conditional's read request until its write is granted. An external arbiter uses this lock to keep any other requester off the memory between the compare and the write. Addresses whose two low bits are not zero are rejected with an alignment error and cause no memory access.

Top module: `llsc_resv_unit`

## Requirements
- R1: A load-linked reads the word at byte address base + sign-extended 16-bit immediate (word address = byte address >> 2) and returns that word on `rsp_rdata`.
- R2: A completed aligned load-linked replaces the reservation with its byte address and the word it loaded.
- R3: A store-conditional whose byte address differs from the reserved address fails with flag 0 and makes no memory access.
- R4: A store-conditional whose address matches, where memory still holds the reserved value, writes `op_wdata` to that word and reports flag 1.
- R5: A store-conditional whose address matches, where memory no longer holds the reserved value, reads once, does not write, and reports flag 0.
- R6: After every aligned store-conditional the reserved address is all ones, so a following store-conditional fails unless a new load-linked comes first.
- R7: A load-linked with destination index 0 returns `rsp_wr_en` = 0; `rsp_wr_en` is 0 for every store-conditional.
- R8: Reset leaves `rsp_valid`, `mem_req`, `mem_lock` and `cond_flag` at 0, `op_ready` at 1, and the reserved address at all ones, so no earlier reservation survives.
- R9: `mem_lock` stays 1 from the store-conditional's read grant until its write is granted, and every write is issued with `mem_lock` = 1.
- R10: An operation whose byte address has either of its two low bits set returns `rsp_align_err` = 1, makes no memory access, and leaves the reservation and `cond_flag` unchanged.
- R11: `cond_flag` holds the result of the most recent aligned store-conditional and keeps that value across load-linked and misaligned operations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | Operation request |
| op_ready | output | 1 | Unit can accept an operation |
| op_kind | input | 1 | 0 = load-linked, 1 = store-conditional |
| op_base | input | 32 | Base address operand |
| op_imm | input | 16 | Signed immediate offset |
| op_dest | input | 5 | Destination register index (load-linked) |
| op_wdata | input | 32 | Store data (store-conditional) |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_is_sc | output | 1 | Response belongs to a store-conditional |
| rsp_rdata | output | 32 | Loaded word |
| rsp_dest | output | 5 | Destination register index |
| rsp_wr_en | output | 1 | Register file write enable |
| rsp_flag | output | 1 | Store-conditional result |
| rsp_align_err | output | 1 | Misaligned address, operation dropped |
| cond_flag | output | 1 | Held result of last store-conditional |
| mem_req | output | 1 | Memory request, held until granted |
| mem_we | output | 1 | Request is a write |
| mem_lock | output | 1 | Keep other requesters off the memory |
| mem_addr | output | 30 | Word address |
| mem_wdata | output | 32 | Write data |
| mem_gnt | input | 1 | Request granted this cycle |
| mem_rvalid | input | 1 | Read data valid (after the grant) |
| mem_rdata | input | 32 | Read data |

## Verification
Every word of a 16-word memory is visited twice, once with a positive and once with a negative immediate, and under both an always-grant and an alternating-grant memory. Each visit runs one pattern chosen by the word index. One pattern is a clean reservation then store, which shows that the write lands. Another has a second requester overwrite the word between the two operations, which separates a value compare from a bare address match. A third stores to a neighbouring address, which must leave the memory untouched. A fourth repeats a store after one has already completed, which shows that the reservation is consumed. Misaligned operations placed between a load-linked and its store show that the reservation and the flag survive them. A reset between a load-linked and its store shows that reset clears the reservation.

// File: rtl/llsc_pkg.sv
// Shared types for the reservation unit: controller states and operation kinds.
package llsc_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LL_RD,
        ST_LL_WAIT,
        ST_SC_RD,
        ST_SC_WAIT,
        ST_SC_WR,
        ST_RESP
    } ctl_state_t;

    typedef enum logic {
        OP_LOAD_LINK  = 1'b0,
        OP_STORE_COND = 1'b1
    } atom_op_t;
endpackage

// File: rtl/llsc_agen.sv
// Effective address generator.
// Adds a sign-extended immediate to the base operand and flags any address
// whose low ALIGN_BITS bits are nonzero. Purely combinational.
// Assumes IMM_W < ADDR_W.
module llsc_agen #(
    parameter int ADDR_W     = 32,
    parameter int IMM_W      = 16,
    parameter int ALIGN_BITS = 2
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [IMM_W-1:0]  imm,
    output logic [ADDR_W-1:0] ea,
    output logic              misaligned
);
    localparam int EXT_W = ADDR_W - IMM_W;

    // Sum base with the sign-extended offset.
    assign ea         = base + {{EXT_W{imm[IMM_W-1]}}, imm};
    // Any set low bit means the word access is not aligned.
    assign misaligned = |ea[ALIGN_BITS-1:0];
endmodule

// File: rtl/llsc_resv.sv
// Reservation holder.
// Keeps the byte address and data word captured by a load-linked. A clear
// (from any aligned store-conditional) sets the address to all ones; since an
// all-ones address is never word aligned, it can never match a real request.
// Clear takes priority over set. Assumes set and clear are single-cycle pulses.
module llsc_resv #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_en,
    input  logic [ADDR_W-1:0] set_addr,
    input  logic [DATA_W-1:0] set_val,
    input  logic              clr_en,
    input  logic [ADDR_W-1:0] probe_addr,
    output logic [ADDR_W-1:0] resv_addr,
    output logic [DATA_W-1:0] resv_val,
    output logic              addr_hit
);
    // Hold or update the reservation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resv_addr <= '1;
            resv_val  <= '0;
        end else if (clr_en) begin
            resv_addr <= '1;
        end else if (set_en) begin
            resv_addr <= set_addr;
            resv_val  <= set_val;
        end
    end

    // Compare an incoming address against the reservation.
    assign addr_hit = (probe_addr == resv_addr);

    assert_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (set_en && !clr_en) |=> (resv_addr == $past(set_addr)) && (resv_val == $past(set_val)));
endmodule

// File: rtl/llsc_ctrl.sv
// Operation controller.
// Accepts one operation at a time. It sequences the memory read for a
// load-linked, and the locked read-compare-write for a store-conditional,
// then emits a one-cycle response. Assumes read data returns strictly after
// its grant, and that the arbiter honours mem_lock.
module llsc_ctrl
    import llsc_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter int REG_W      = 5,
    parameter int ALIGN_BITS = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     op_valid,
    input  logic                     op_kind,
    input  logic [ADDR_W-1:0]        ea,
    input  logic                     misaligned,
    input  logic [REG_W-1:0]         op_dest,
    input  logic [DATA_W-1:0]        op_wdata,
    input  logic                     addr_hit,
    input  logic [DATA_W-1:0]        resv_val,
    output logic                     op_ready,
    output logic                     mem_req,
    output logic                     mem_we,
    output logic                     mem_lock,
    output logic [ADDR_W-ALIGN_BITS-1:0] mem_addr,
    output logic [DATA_W-1:0]        mem_wdata,
    input  logic                     mem_gnt,
    input  logic                     mem_rvalid,
    input  logic [DATA_W-1:0]        mem_rdata,
    output logic                     resv_set,
    output logic [ADDR_W-1:0]        resv_set_addr,
    output logic [DATA_W-1:0]        resv_set_val,
    output logic                     resv_clr,
    output logic                     rsp_valid,
    output logic                     rsp_is_sc,
    output logic [DATA_W-1:0]        rsp_rdata,
    output logic [REG_W-1:0]         rsp_dest,
    output logic                     rsp_wr_en,
    output logic                     rsp_flag,
    output logic                     rsp_align_err,
    output logic                     cond_flag
);
    ctl_state_t          state_q, state_d;
    atom_op_t            kind_q;
    logic [ADDR_W-1:0]   ea_q;
    logic [REG_W-1:0]    dest_q;
    logic [DATA_W-1:0]   wdata_q;
    logic [DATA_W-1:0]   rdata_q;
    logic                err_q;
    logic                flag_q;
    logic                accept;

    assign op_ready = (state_q == ST_IDLE);
    assign accept   = op_ready && op_valid;

    // Next-state selection.
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE: begin
                if (op_valid) begin
                    if (misaligned)                           state_d = ST_RESP;
                    else if (atom_op_t'(op_kind) == OP_LOAD_LINK) state_d = ST_LL_RD;
                    else if (addr_hit)                        state_d = ST_SC_RD;
                    else                                      state_d = ST_RESP;
                end
            end
            ST_LL_RD:   if (mem_gnt)    state_d = ST_LL_WAIT;
            ST_LL_WAIT: if (mem_rvalid) state_d = ST_RESP;
            ST_SC_RD:   if (mem_gnt)    state_d = ST_SC_WAIT;
            ST_SC_WAIT: if (mem_rvalid) state_d = (mem_rdata == resv_val) ? ST_SC_WR : ST_RESP;
            ST_SC_WR:   if (mem_gnt)    state_d = ST_RESP;
            ST_RESP:                    state_d = ST_IDLE;
            default:                    state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Capture the accepted operation and build the response fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind_q  <= OP_LOAD_LINK;
            ea_q    <= '0;
            dest_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
            err_q   <= 1'b0;
            flag_q  <= 1'b0;
        end else begin
            if (accept) begin
                kind_q  <= atom_op_t'(op_kind);
                ea_q    <= ea;
                dest_q  <= op_dest;
                wdata_q <= op_wdata;
                rdata_q <= '0;
                err_q   <= misaligned;
                flag_q  <= 1'b0;
            end
            if (state_q == ST_LL_WAIT && mem_rvalid) rdata_q <= mem_rdata;
            if (state_q == ST_SC_WR && mem_gnt)      flag_q  <= 1'b1;
        end
    end

    // Persistent result flag, updated only by aligned store-conditionals.
    always_ff @(posedge clk) begin
        if (!rst_n)                                             cond_flag <= 1'b0;
        else if (state_q == ST_RESP && kind_q == OP_STORE_COND && !err_q) cond_flag <= flag_q;
    end

    // Memory port drive.
    assign mem_req   = (state_q == ST_LL_RD) || (state_q == ST_SC_RD) || (state_q == ST_SC_WR);
    assign mem_we    = (state_q == ST_SC_WR);
    assign mem_lock  = (state_q == ST_SC_RD) || (state_q == ST_SC_WAIT) || (state_q == ST_SC_WR);
    assign mem_addr  = ea_q[ADDR_W-1:ALIGN_BITS];
    assign mem_wdata = wdata_q;

    // Reservation updates.
    assign resv_set      = (state_q == ST_LL_WAIT) && mem_rvalid;
    assign resv_set_addr = ea_q;
    assign resv_set_val  = mem_rdata;
    assign resv_clr      = (state_q == ST_RESP) && (kind_q == OP_STORE_COND) && !err_q;

    // Response outputs.
    assign rsp_valid     = (state_q == ST_RESP);
    assign rsp_is_sc     = (kind_q == OP_STORE_COND);
    assign rsp_rdata     = rdata_q;
    assign rsp_dest      = dest_q;
    assign rsp_wr_en     = rsp_valid && (kind_q == OP_LOAD_LINK) && !err_q && (dest_q != '0);
    assign rsp_flag      = flag_q;
    assign rsp_align_err = err_q;

    assert_write_locked_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> mem_lock);
    assert_lock_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mem_lock) && !mem_lock) |-> rsp_valid);
    assert_misaligned_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && misaligned) |=> (!mem_req && rsp_valid && rsp_align_err));
    assert_mismatch_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !misaligned && op_kind && !addr_hit) |=> (!mem_req && rsp_valid && !rsp_flag));
    assert_success_wrote_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_flag) |-> $past(mem_req && mem_we && mem_gnt));
    assert_reg0_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && (rsp_dest == '0 || rsp_is_sc)) |-> !rsp_wr_en);
endmodule

// File: rtl/llsc_resv_unit.sv
// Load-linked / store-conditional reservation unit, top level.
// Ties the address generator, the reservation holder and the controller
// together. Assumes one outstanding operation and a word-wide memory port
// whose arbiter keeps other requesters out while mem_lock is high.
module llsc_resv_unit #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int IMM_W  = 16,
    parameter int REG_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    output logic              op_ready,
    input  logic              op_kind,
    input  logic [ADDR_W-1:0] op_base,
    input  logic [IMM_W-1:0]  op_imm,
    input  logic [REG_W-1:0]  op_dest,
    input  logic [DATA_W-1:0] op_wdata,
    output logic              rsp_valid,
    output logic              rsp_is_sc,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [REG_W-1:0]  rsp_dest,
    output logic              rsp_wr_en,
    output logic              rsp_flag,
    output logic              rsp_align_err,
    output logic              cond_flag,
    output logic              mem_req,
    output logic              mem_we,
    output logic              mem_lock,
    output logic [ADDR_W-$clog2(DATA_W/8)-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_gnt,
    input  logic              mem_rvalid,
    input  logic [DATA_W-1:0] mem_rdata
);
    localparam int ALIGN_BITS = $clog2(DATA_W / 8);

    logic [ADDR_W-1:0] ea;
    logic              misaligned;
    logic              addr_hit;
    logic [ADDR_W-1:0] resv_addr;
    logic [DATA_W-1:0] resv_val;
    logic              resv_set;
    logic              resv_clr;
    logic [ADDR_W-1:0] resv_set_addr;
    logic [DATA_W-1:0] resv_set_val;

    llsc_agen #(.ADDR_W(ADDR_W), .IMM_W(IMM_W), .ALIGN_BITS(ALIGN_BITS)) agen_i (
        .base       (op_base),
        .imm        (op_imm),
        .ea         (ea),
        .misaligned (misaligned)
    );

    llsc_resv #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) resv_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_en     (resv_set),
        .set_addr   (resv_set_addr),
        .set_val    (resv_set_val),
        .clr_en     (resv_clr),
        .probe_addr (ea),
        .resv_addr  (resv_addr),
        .resv_val   (resv_val),
        .addr_hit   (addr_hit)
    );

    llsc_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_W(REG_W), .ALIGN_BITS(ALIGN_BITS)) ctrl_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .op_valid      (op_valid),
        .op_kind       (op_kind),
        .ea            (ea),
        .misaligned    (misaligned),
        .op_dest       (op_dest),
        .op_wdata      (op_wdata),
        .addr_hit      (addr_hit),
        .resv_val      (resv_val),
        .op_ready      (op_ready),
        .mem_req       (mem_req),
        .mem_we        (mem_we),
        .mem_lock      (mem_lock),
        .mem_addr      (mem_addr),
        .mem_wdata     (mem_wdata),
        .mem_gnt       (mem_gnt),
        .mem_rvalid    (mem_rvalid),
        .mem_rdata     (mem_rdata),
        .resv_set      (resv_set),
        .resv_set_addr (resv_set_addr),
        .resv_set_val  (resv_set_val),
        .resv_clr      (resv_clr),
        .rsp_valid     (rsp_valid),
        .rsp_is_sc     (rsp_is_sc),
        .rsp_rdata     (rsp_rdata),
        .rsp_dest      (rsp_dest),
        .rsp_wr_en     (rsp_wr_en),
        .rsp_flag      (rsp_flag),
        .rsp_align_err (rsp_align_err),
        .cond_flag     (cond_flag)
    );

    assert_resv_gone_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_is_sc && !rsp_align_err) |=> (resv_addr == '1));
    assert_misaligned_keeps_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_align_err) |=> $stable(resv_addr) && $stable(cond_flag));
endmodule

// File: tb/llsc_resv_unit_tb_top.sv
// Self-checking bench: 16-word memory model with an optional alternating
// grant, a second requester gated by mem_lock, and an arithmetic model of the
// reservation.
module llsc_resv_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic        op_kind = 1'b0;
    logic [31:0] op_base = '0;
    logic [15:0] op_imm = '0;
    logic [4:0]  op_dest = '0;
    logic [31:0] op_wdata = '0;
    logic        op_ready, rsp_valid, rsp_is_sc, rsp_wr_en, rsp_flag, rsp_align_err, cond_flag;
    logic [31:0] rsp_rdata;
    logic [4:0]  rsp_dest;
    logic        mem_req, mem_we, mem_lock;
    logic [29:0] mem_addr;
    logic [31:0] mem_wdata;
    logic        mem_gnt;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;

    always #10 clk = ~clk;

    llsc_resv_unit dut_i (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
        .op_kind(op_kind), .op_base(op_base), .op_imm(op_imm), .op_dest(op_dest),
        .op_wdata(op_wdata), .rsp_valid(rsp_valid), .rsp_is_sc(rsp_is_sc),
        .rsp_rdata(rsp_rdata), .rsp_dest(rsp_dest), .rsp_wr_en(rsp_wr_en),
        .rsp_flag(rsp_flag), .rsp_align_err(rsp_align_err), .cond_flag(cond_flag),
        .mem_req(mem_req), .mem_we(mem_we), .mem_lock(mem_lock), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid),
        .mem_rdata(mem_rdata)
    );

    // Memory model and second requester
    logic [31:0] mem_m [16];
    logic        stall_mode = 1'b0;
    logic [3:0]  cyc = '0;
    logic        oth_req = 1'b0;
    logic [3:0]  oth_idx = '0;
    logic [31:0] oth_data = '0;

    assign mem_gnt = mem_req && (!stall_mode || cyc[0]);

    always @(posedge clk) begin
        cyc        <= cyc + 4'd1;
        mem_rvalid <= mem_req && !mem_we && mem_gnt;
        mem_rdata  <= mem_m[mem_addr[3:0]];
        if (mem_req && mem_we && mem_gnt)
            mem_m[mem_addr[3:0]] <= mem_wdata;
        else if (oth_req && !mem_req && !mem_lock)
            mem_m[oth_idx] <= oth_data;
    end

    // Bench model
    int          n_cmp = 0;
    int          n_bad = 0;
    logic [31:0] exp_mem [16];
    logic [31:0] exp_resv_addr = '1;
    logic [31:0] exp_resv_val = '0;
    logic        exp_flag = 1'b0;
    bit          done = 1'b0;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic other_write(input logic [3:0] idx, input logic [31:0] data);
        @(negedge clk);
        oth_req = 1'b1; oth_idx = idx; oth_data = data;
        @(negedge clk);
        oth_req = 1'b0;
        exp_mem[idx] = data;
    endtask

    // Issue one operation, predict its outcome, and compare at the ports.
    task automatic exec(input logic kind, input logic [31:0] base, input logic [15:0] imm,
                        input logic [4:0] dest, input logic [31:0] wd, input string tag);
        logic [31:0] ea;
        logic [3:0]  idx;
        bit          mis, e_flag, e_wr;
        int          e_acc, acc, n;
        bit          rd_seen, wr_seen, lock_bad;
        logic [31:0] e_data;
        ea  = base + {{16{imm[15]}}, imm};
        idx = ea[5:2];
        mis = (ea[1:0] != 2'b00);
        e_flag = 1'b0; e_wr = 1'b0; e_acc = 0; e_data = '0;
        if (mis) begin
            e_acc = 0;
        end else if (!kind) begin
            e_data = exp_mem[idx]; e_wr = (dest != 5'd0); e_acc = 1;
            exp_resv_addr = ea; exp_resv_val = exp_mem[idx];
        end else begin
            if (ea == exp_resv_addr) begin
                if (exp_mem[idx] == exp_resv_val) begin
                    e_flag = 1'b1; e_acc = 2; exp_mem[idx] = wd;
                end else e_acc = 1;
            end
            exp_resv_addr = '1;
            exp_flag = e_flag;
        end
        @(negedge clk);
        check(op_ready == 1'b1, "R8", {31'd0, op_ready}, 32'd1);
        op_valid = 1'b1; op_kind = kind; op_base = base; op_imm = imm; op_dest = dest; op_wdata = wd;
        @(negedge clk);
        op_valid = 1'b0;
        acc = 0; n = 0; rd_seen = 0; wr_seen = 0; lock_bad = 0;
        while (!rsp_valid && n < 100) begin
            if (rd_seen && !wr_seen && !mem_lock) lock_bad = 1;
            if (mem_req && mem_gnt) begin
                acc++;
                if (mem_we) begin
                    wr_seen = 1;
                    if (!mem_lock) lock_bad = 1;
                end else if (kind) rd_seen = 1;
            end
            @(negedge clk);
            n++;
        end
        check(rsp_valid == 1'b1, tag, {31'd0, rsp_valid}, 32'd1);
        check(rsp_align_err == mis, "R10", {31'd0, rsp_align_err}, {31'd0, mis});
        check(acc == e_acc, mis ? "R10" : tag, acc, e_acc);
        check(rsp_wr_en == e_wr, "R7", {31'd0, rsp_wr_en}, {31'd0, e_wr});
        check(!lock_bad, "R9", {31'd0, lock_bad}, 32'd0);
        if (kind && !mis) check(rsp_flag == e_flag, tag, {31'd0, rsp_flag}, {31'd0, e_flag});
        if (!kind && !mis) begin
            check(rsp_rdata == e_data, "R1", rsp_rdata, e_data);
            check(rsp_dest == dest, "R1", {27'd0, rsp_dest}, {27'd0, dest});
        end
        @(negedge clk);
        check(cond_flag == exp_flag, "R11", {31'd0, cond_flag}, {31'd0, exp_flag});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // Reset state R8
        check(rsp_valid == 1'b0 && mem_req == 1'b0 && mem_lock == 1'b0, "R8",
              {29'd0, rsp_valid, mem_req, mem_lock}, 32'd0);
        check(cond_flag == 1'b0, "R8", {31'd0, cond_flag}, 32'd0);
        check(op_ready == 1'b1, "R8", {31'd0, op_ready}, 32'd1);
        rst_n = 1'b1;
        for (int i = 0; i < 16; i++) other_write(i[3:0], 32'hA5C3_0000 ^ (i * 32'h0101_1111));
        // Fresh reservation is empty: SC to word 0 must fail without access (R8)
        exec(1'b1, 32'd0, 16'd0, 5'd0, 32'h1234_5678, "R8");

        for (int w = 0; w < 16; w++) begin
            for (int s = 0; s < 2; s++) begin
                logic [31:0] ea, b;
                logic [15:0] im;
                stall_mode = s[0];
                ea = w * 4;
                if (s != 0) begin b = ea + 32'd100; im = 16'hFF9C; end
                else        begin b = ea - 32'd40;  im = 16'd40;   end
                case (w % 4)
                    0: begin
                        exec(1'b0, b, im, 5'(w + 1), '0, "R2");
                        exec(1'b0, b + 32'(w % 3 + 1), im, 5'd4, '0, "R10");
                        exec(1'b1, b + 32'(w % 3 + 1), im, 5'd0, 32'hDEAD_0000 + w, "R10");
                        exec(1'b1, b, im, 5'd0, 32'hC0DE_0000 + (w << 4) + s, "R4");
                    end
                    1: begin
                        exec(1'b0, b, im, 5'd7, '0, "R1");
                        other_write(ea[5:2], exp_mem[ea[5:2]] ^ 32'h0000_0100);
                        exec(1'b1, b, im, 5'd0, 32'hBAD0_0000 + w, "R5");
                    end
                    2: begin
                        exec(1'b0, b, im, 5'd31, '0, "R2");
                        exec(1'b1, b, im, 5'd0, 32'h5EED_0000 + (w << 4) + s, "R4");
                        exec(1'b1, b, im, 5'd0, 32'h0BAD_0000 + w, "R6");
                    end
                    default: begin
                        exec(1'b0, b, im, 5'd0, '0, "R7");
                        exec(1'b1, b + 32'd4, im, 5'd0, 32'hFACE_0000 + w, "R3");
                        exec(1'b1, b, im, 5'd0, 32'hFEED_0000 + w, "R6");
                    end
                endcase
            end
        end

        // Reset between load-linked and store-conditional R8
        stall_mode = 1'b0;
        exec(1'b0, 32'd32, 16'd0, 5'd2, '0, "R2");
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        check(cond_flag == 1'b0 && mem_lock == 1'b0, "R8", {30'd0, cond_flag, mem_lock}, 32'd0);
        rst_n = 1'b1;
        exp_resv_addr = '1; exp_flag = 1'b0;
        exec(1'b1, 32'd32, 16'd0, 5'd0, 32'h7777_7777, "R8");

        // Final readback of every word R4
        for (int i = 0; i < 16; i++) exec(1'b0, 32'(i * 4), 16'd0, 5'd1, '0, "R4");

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule